// File: doc/BRIEF.md
# One-Shot / Free-Running PWM Timer Unit

This block is a 16-bit up-counter with one period register and four compare registers. It produces single-cycle event pulses when the count matches the period or one of the compares. A two-bit mode selection decides how counting starts and stops. In free-running mode the counter starts as soon as the timer is enabled and wraps after the period. In the two one-shot modes, enabling only arms the timer. An external reset-event strobe then launches a single run that halts at the period value. The retriggerable variant restarts the run when a reset event arrives mid-run. The non-retriggerable variant ignores such events until the run ends.

Period and compare values are loaded through a simple write port. Each write is checked against a legal window that depends on a 3-bit prescaler code. An illegal write leaves the register unchanged and sets a sticky error flag, which only reset clears. The prescaler code selects only the legal window; the counter advances by one on every clock while it runs.

Top module: `oneshot_pwm_timer`

## Requirements
- R1: The mode is decoded from `mode_cont` and `mode_retrig`. `mode_cont=1` selects free-running whatever `mode_retrig` is. `mode_cont=0, mode_retrig=0` selects the non-retriggerable one-shot. `mode_cont=0, mode_retrig=1` selects the retriggerable one-shot.
- R2: In free-running mode, the first clock edge with `tmr_en=1` starts the counter at 0. On each later edge the count rises by one. An edge at which the count equals the period returns the count to 0 and raises `per_evt_o`, so events repeat every period+1 cycles.
- R3: In free-running mode, a reset event clears the count to 0 at the next edge, even when the count equals the period. A period event is never raised for that edge.
- R4: In either one-shot mode, `tmr_en=1` alone never starts counting (`running_o` stays 0). A reset event while stopped and enabled starts a run at count 0.
- R5: In the non-retriggerable one-shot, a reset event during a run is ignored and the count keeps incrementing.
- R6: In the retriggerable one-shot, a reset event during a run clears the count to 0 and the run continues.
- R7: In either one-shot mode, reaching the period raises `per_evt_o`, drops `running_o` and freezes the count. A later reset event starts a new run from 0.
- R8: With `tmr_en=0`, the next edge forces `running_o=0` and a count of 0. After reset the count, `running_o`, all events and `cfg_err_o` are 0.
- R9: Compare channel k raises `cmp_evt_o[k-1]` in the cycle after an edge at which the running count equals its value. It does so only if that value is nonzero and no larger than the period. A compare equal to the period pulses together with `per_evt_o`.
- R10: Writing 0 is legal only on compare channels 1 and 3, and it disables their events. Writing 0 to the period or to channels 2 and 4 is an illegal write.
- R11: A write is legal when its value lies between a minimum and a maximum that depend on the prescaler code. The minimums for codes 0 to 4 are 0x0060, 0x0030, 0x0018, 0x000C and 0x0006, and 0x0003 for codes 5 to 7. The maximums for codes 0 to 4 are 0xFFDF, 0xFFEF, 0xFFF7, 0xFFFB and 0xFFFD, and 0xFFFD for codes 5 to 7.
- R12: An illegal write, including one to a `wr_sel` value above 4, leaves every register unchanged and sets `cfg_err_o` one edge later. `cfg_err_o` then stays 1 until reset. `wr_sel=0` addresses the period register and `wr_sel=k` (1 to 4) addresses compare channel k.
- R13: Every event output is high for a single cycle per match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Timer enable |
| mode_cont | input | 1 | Free-running select |
| mode_retrig | input | 1 | Retrigger select for one-shot modes |
| reset_evt | input | 1 | Reset-event strobe (start/clear) |
| psc_code | input | 3 | Prescaler code selecting the legal value window |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 period, 1..4 compare channel |
| wr_data | input | 16 | Write value |
| cnt_o | output | 16 | Current count |
| running_o | output | 1 | Counter is running |
| per_evt_o | output | 1 | Period event pulse |
| cmp_evt_o | output | 4 | Compare event pulses, bit k-1 for channel k |
| cfg_err_o | output | 1 | Sticky illegal-write flag |

## Verification
A wrong run/stop state shows up on `running_o` and `cnt_o` one edge after the stimulus that caused it. Examples are a one-shot that starts on enable, or one that fails to halt at the period. A retrigger handled in the wrong mode alters the count at the very next edge. A wrong count or a wrongly retained register value shifts the period and compare pulses by whole cycles, so the bench checks pulse positions cycle by cycle. A limit-table error appears on `cfg_err_o` one edge after the offending write.

// File: rtl/opt_pkg.sv
package opt_pkg;

    localparam int CNT_W = 16;
    localparam int PSC_W = 3;

    typedef enum logic [1:0] {
        MODE_FREE      = 2'd0,
        MODE_OS_HOLD   = 2'd1,
        MODE_OS_RETRIG = 2'd2
    } run_mode_e;

    function automatic run_mode_e decode_mode(input logic cont, input logic retrig);
        if (cont)        return MODE_FREE;
        else if (retrig) return MODE_OS_RETRIG;
        else             return MODE_OS_HOLD;
    endfunction

    function automatic logic [CNT_W-1:0] range_min(input logic [PSC_W-1:0] code);
        case (code)
            3'd0:    return 16'h0060;
            3'd1:    return 16'h0030;
            3'd2:    return 16'h0018;
            3'd3:    return 16'h000C;
            3'd4:    return 16'h0006;
            default: return 16'h0003;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] range_max(input logic [PSC_W-1:0] code);
        case (code)
            3'd0:    return 16'hFFDF;
            3'd1:    return 16'hFFEF;
            3'd2:    return 16'hFFF7;
            3'd3:    return 16'hFFFB;
            default: return 16'hFFFD;
        endcase
    endfunction

endpackage

// File: rtl/opt_regs.sv
module opt_regs
    import opt_pkg::*;
#(
    parameter int              NUM_CMP = 4,
    parameter logic [NUM_CMP-1:0] ZERO_OK = 4'b0101,
    parameter int              SEL_W   = 3,
    parameter logic [CNT_W-1:0] PER_RST = 16'hFFDF
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [PSC_W-1:0]                psc_code,
    input  logic                            wr_en,
    input  logic [SEL_W-1:0]                wr_sel,
    input  logic [CNT_W-1:0]                wr_data,
    output logic [CNT_W-1:0]                per_val,
    output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val,
    output logic                            cfg_err
);

    logic [CNT_W-1:0] lo_lim, hi_lim;
    logic             fits;
    logic [NUM_CMP:0] sel_hit;
    logic [NUM_CMP:0] val_ok;
    logic             bad_wr;

    assign lo_lim = range_min(psc_code);
    assign hi_lim = range_max(psc_code);
    assign fits   = (wr_data >= lo_lim) && (wr_data <= hi_lim);

    always_comb begin
        sel_hit[0] = (wr_sel == '0);
        val_ok[0]  = fits;
        for (int i = 0; i < NUM_CMP; i++) begin
            sel_hit[i+1] = (wr_sel == SEL_W'(i + 1));
            val_ok[i+1]  = fits || (ZERO_OK[i] && (wr_data == '0));
        end
    end

    assign bad_wr = wr_en && ((sel_hit & val_ok) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_val <= PER_RST;
            cmp_val <= '0;
            cfg_err <= 1'b0;
        end else begin
            if (wr_en && sel_hit[0] && val_ok[0])
                per_val <= wr_data;
            for (int i = 0; i < NUM_CMP; i++) begin
                if (wr_en && sel_hit[i+1] && val_ok[i+1])
                    cmp_val[i] <= wr_data;
            end
            if (bad_wr)
                cfg_err <= 1'b1;
        end
    end

    AST_BAD_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> ($stable(per_val) && $stable(cmp_val) && cfg_err)) // R12
        else $error("illegal write altered a register");

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err) // R12
        else $error("error flag cleared without reset");

endmodule

// File: rtl/opt_counter.sv
module opt_counter
    import opt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_en,
    input  run_mode_e        mode,
    input  logic             reset_evt,
    input  logic [CNT_W-1:0] per_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             running_o,
    output logic             per_evt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             running_q;
    logic             per_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
            per_q     <= 1'b0;
        end else begin
            per_q <= 1'b0;
            if (!tmr_en) begin
                running_q <= 1'b0;
                cnt_q     <= '0;
            end else if (!running_q) begin
                if (mode == MODE_FREE || reset_evt) begin
                    running_q <= 1'b1;
                    cnt_q     <= '0;
                end
            end else if (reset_evt && mode != MODE_OS_HOLD) begin
                cnt_q <= '0;
            end else if (cnt_q == per_val) begin
                per_q <= 1'b1;
                if (mode == MODE_FREE) cnt_q     <= '0;
                else                   running_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign running_o = running_q;
    assign per_evt_o = per_q;

    AST_EN_OFF: assert property (@(posedge clk) disable iff (rst)
        !tmr_en |=> (!running_q && cnt_q == '0)) // R8
        else $error("disable did not stop the counter");

    AST_OS_NO_SELF_START: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_FREE && !running_q && !reset_evt) |=> !running_q) // R4
        else $error("one-shot started without a reset event");

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_FREE && tmr_en && !running_q && !reset_evt) |=> $stable(cnt_q)) // R7
        else $error("halted count moved");

    AST_NRT_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OS_HOLD && tmr_en && running_q && reset_evt && cnt_q != per_val)
        |=> (cnt_q == $past(cnt_q) + 1'b1)) // R5
        else $error("non-retriggerable run was disturbed");

    AST_PER_PULSE: assert property (@(posedge clk) disable iff (rst)
        per_q |=> !per_q) // R13
        else $error("period event longer than one cycle");

endmodule

// File: rtl/opt_compare.sv
module opt_compare
    import opt_pkg::*;
#(
    parameter int NUM_CMP = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CNT_W-1:0]              cnt,
    input  logic                          running,
    input  logic [CNT_W-1:0]              per_val,
    input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val,
    output logic [NUM_CMP-1:0]            cmp_evt
);

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_ch
        logic evt_q;
        logic armed;

        assign armed = (cmp_val[g] != '0) && (cmp_val[g] <= per_val);

        always_ff @(posedge clk) begin
            if (rst) evt_q <= 1'b0;
            else     evt_q <= running && armed && (cnt == cmp_val[g]);
        end

        assign cmp_evt[g] = evt_q;

        AST_CMP_LEGAL: assert property (@(posedge clk) disable iff (rst)
            evt_q |-> ($past(cmp_val[g]) != '0 && $past(cmp_val[g]) <= $past(per_val))) // R9
            else $error("compare event from a disabled or out-of-range compare");

        AST_CMP_PULSE: assert property (@(posedge clk) disable iff (rst)
            evt_q |=> !evt_q) // R13
            else $error("compare event longer than one cycle");
    end

endmodule

// File: rtl/oneshot_pwm_timer.sv
module oneshot_pwm_timer
    import opt_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter logic [NUM_CMP-1:0] ZERO_OK = 4'b0101,
    localparam int SEL_W = $clog2(NUM_CMP + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tmr_en,
    input  logic               mode_cont,
    input  logic               mode_retrig,
    input  logic               reset_evt,
    input  logic [PSC_W-1:0]   psc_code,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               running_o,
    output logic               per_evt_o,
    output logic [NUM_CMP-1:0] cmp_evt_o,
    output logic               cfg_err_o
);

    run_mode_e                     mode;
    logic [CNT_W-1:0]              per_val;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;

    assign mode = decode_mode(mode_cont, mode_retrig);

    opt_regs #(
        .NUM_CMP (NUM_CMP),
        .ZERO_OK (ZERO_OK),
        .SEL_W   (SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .psc_code (psc_code),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .per_val  (per_val),
        .cmp_val  (cmp_val),
        .cfg_err  (cfg_err_o)
    );

    opt_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tmr_en    (tmr_en),
        .mode      (mode),
        .reset_evt (reset_evt),
        .per_val   (per_val),
        .cnt_o     (cnt_o),
        .running_o (running_o),
        .per_evt_o (per_evt_o)
    );

    opt_compare #(
        .NUM_CMP (NUM_CMP)
    ) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt_o),
        .running (running_o),
        .per_val (per_val),
        .cmp_val (cmp_val),
        .cmp_evt (cmp_evt_o)
    );

endmodule

// File: tb/oneshot_pwm_timer_tb.sv
module oneshot_pwm_timer_tb;

    logic        clk = 1'b0;
    logic        rst, tmr_en, mode_cont, mode_retrig, reset_evt, wr_en;
    logic [2:0]  psc_code, wr_sel;
    logic [15:0] wr_data, cnt_o;
    logic        running_o, per_evt_o, cfg_err_o;
    logic [3:0]  cmp_evt_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    oneshot_pwm_timer u_dut (
        .clk(clk), .rst(rst), .tmr_en(tmr_en), .mode_cont(mode_cont),
        .mode_retrig(mode_retrig), .reset_evt(reset_evt), .psc_code(psc_code),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .cnt_o(cnt_o),
        .running_o(running_o), .per_evt_o(per_evt_o), .cmp_evt_o(cmp_evt_o),
        .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; tmr_en = 1'b0; mode_cont = 1'b0; mode_retrig = 1'b0;
        reset_evt = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; psc_code = 3'd7;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_reset_evt();
        reset_evt = 1'b1;
        tick();
        reset_evt = 1'b0;
    endtask

    function automatic int exp_min(input int code);
        return (code >= 5) ? 3 : (16'h60 >> code);
    endfunction

    function automatic int exp_max(input int code);
        return (code >= 5) ? 16'hFFFD : (16'hFFFF - (16'h20 >> code));
    endfunction

    task automatic t_reset_state();
        do_reset();
        chk(running_o == 1'b0, "R8 reset running", running_o, 0);
        chk(cnt_o == 16'd0, "R8 reset count", cnt_o, 0);
        chk(per_evt_o == 1'b0 && cmp_evt_o == 4'd0, "R8 reset events", {cmp_evt_o, per_evt_o}, 0);
        chk(cfg_err_o == 1'b0, "R8 reset error flag", cfg_err_o, 0);
    endtask

    task automatic t_limits();
        for (int code = 0; code < 8; code++) begin
            do_reset();
            psc_code = 3'(code);
            wr(3'd0, 16'(exp_min(code)));
            chk(cfg_err_o == 1'b0, "R11 minimum accepted", cfg_err_o, 0);
            wr(3'd1, 16'(exp_max(code)));
            chk(cfg_err_o == 1'b0, "R11 maximum accepted", cfg_err_o, 0);
            wr(3'd2, 16'(exp_min(code) - 1));
            chk(cfg_err_o == 1'b1, "R11 below minimum rejected", cfg_err_o, 1);
            do_reset();
            psc_code = 3'(code);
            wr(3'd4, 16'(exp_max(code) + 1));
            chk(cfg_err_o == 1'b1, "R11 above maximum rejected", cfg_err_o, 1);
        end
    endtask

    task automatic t_setup_writes();
        do_reset();
        psc_code = 3'd7;
        wr(3'd0, 16'd5);
        wr(3'd1, 16'd5);
        wr(3'd3, 16'd0);
        chk(cfg_err_o == 1'b0, "R10 zero legal on channel 3", cfg_err_o, 0);
        wr(3'd1, 16'd0);
        chk(cfg_err_o == 1'b0, "R10 zero legal on channel 1", cfg_err_o, 0);
        wr(3'd1, 16'd5);
        wr(3'd2, 16'd4);
        wr(3'd4, 16'd7);
        chk(cfg_err_o == 1'b0, "R12 legal writes leave flag clear", cfg_err_o, 0);
        wr(3'd2, 16'd0);
        chk(cfg_err_o == 1'b1, "R10 zero illegal on channel 2", cfg_err_o, 1);
        wr(3'd0, 16'd2);
        wr(3'd0, 16'hFFFE);
        wr(3'd6, 16'd9);
        chk(cfg_err_o == 1'b1, "R12 flag sticky", cfg_err_o, 1);
    endtask

    task automatic t_free_run();
        mode_cont = 1'b1; mode_retrig = 1'b0; tmr_en = 1'b1;
        tick();
        chk(running_o == 1'b1 && cnt_o == 16'd0, "R2 start on enable", cnt_o, 0);
        for (int k = 1; k <= 12; k++) begin
            logic       ep;
            logic [3:0] ec;
            tick();
            ep = ((k - 1) % 6 == 5);
            ec = {1'b0, 1'b0, ((k - 1) % 6 == 4), ep};
            chk(cnt_o == 16'(k % 6), "R2/R12 count and wrap with retained period", cnt_o, k % 6);
            chk(per_evt_o == ep, "R2/R13 period pulse", per_evt_o, ep);
            chk(cmp_evt_o == ec, "R9/R10 compare pulses", cmp_evt_o, ec);
        end
    endtask

    task automatic t_free_reset();
        tick(); tick(); tick();
        pulse_reset_evt();
        chk(cnt_o == 16'd0, "R3 reset event clears count", cnt_o, 0);
        chk(per_evt_o == 1'b0, "R3 no period event", per_evt_o, 0);
        tick(); tick(); tick(); tick(); tick();
        chk(cnt_o == 16'd5, "R3 count resumes", cnt_o, 5);
        pulse_reset_evt();
        chk(cnt_o == 16'd0 && per_evt_o == 1'b0, "R3 reset at period suppresses period event", per_evt_o, 0);
        chk(cmp_evt_o == 4'b0001, "R9 compare still reported", cmp_evt_o, 1);
    endtask

    task automatic t_disable();
        tmr_en = 1'b0;
        tick();
        chk(running_o == 1'b0 && cnt_o == 16'd0, "R8 disable stops", cnt_o, 0);
        tick();
        chk(running_o == 1'b0 && per_evt_o == 1'b0, "R8 stays stopped", running_o, 0);
    endtask

    task automatic t_mode_priority();
        mode_cont = 1'b1; mode_retrig = 1'b1; tmr_en = 1'b1;
        tick();
        chk(running_o == 1'b1 && cnt_o == 16'd0, "R1 continuous overrides retrigger", running_o, 1);
        tmr_en = 1'b0;
        tick();
    endtask

    task automatic t_oneshot_hold();
        mode_cont = 1'b0; mode_retrig = 1'b0; tmr_en = 1'b1;
        tick(); tick(); tick();
        chk(running_o == 1'b0 && cnt_o == 16'd0, "R4 enable only arms", running_o, 0);
        pulse_reset_evt();
        chk(running_o == 1'b1 && cnt_o == 16'd0, "R4 reset event starts", cnt_o, 0);
        tick(); tick();
        pulse_reset_evt();
        chk(cnt_o == 16'd3 && running_o == 1'b1, "R5 retrigger ignored", cnt_o, 3);
        tick(); tick();
        chk(per_evt_o == 1'b0 && cnt_o == 16'd5, "R5 run undisturbed", cnt_o, 5);
        tick();
        chk(per_evt_o == 1'b1, "R7 period event at end", per_evt_o, 1);
        chk(running_o == 1'b0, "R7 halts at period", running_o, 0);
        tick();
        chk(per_evt_o == 1'b0, "R13 single-cycle period event", per_evt_o, 0);
        chk(running_o == 1'b0 && cnt_o == 16'd5, "R7 count frozen", cnt_o, 5);
        pulse_reset_evt();
        chk(running_o == 1'b1 && cnt_o == 16'd0, "R7 restart from zero", cnt_o, 0);
        tmr_en = 1'b0;
        tick();
    endtask

    task automatic t_oneshot_retrig();
        mode_cont = 1'b0; mode_retrig = 1'b1; tmr_en = 1'b1;
        tick();
        chk(running_o == 1'b0, "R4 retriggerable mode arms only", running_o, 0);
        pulse_reset_evt();
        chk(running_o == 1'b1 && cnt_o == 16'd0, "R6 first reset event starts", cnt_o, 0);
        tick(); tick(); tick();
        pulse_reset_evt();
        chk(cnt_o == 16'd0 && running_o == 1'b1, "R6 retrigger clears and continues", cnt_o, 0);
        tick(); tick(); tick(); tick(); tick();
        chk(cnt_o == 16'd5 && per_evt_o == 1'b0, "R6 count after retrigger", cnt_o, 5);
        tick();
        chk(per_evt_o == 1'b1 && running_o == 1'b0, "R6 run ends one period after retrigger", per_evt_o, 1);
        tmr_en = 1'b0;
        tick();
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_limits();
        t_setup_writes();
        t_free_run();
        t_free_reset();
        t_disable();
        t_mode_priority();
        t_oneshot_hold();
        t_oneshot_retrig();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule